// File: doc/BRIEF.md
# Two-Bit Subexpression Shift-and-Add Multiplier

This block forms the full-precision product of a signed 16-bit sample and a run-time programmable 16-bit coefficient. It contains no general multiplier. The coefficient arrives in sign-magnitude form: bit 15 is the sign and bits 14:0 are the magnitude. Its magnitude is read as eight 2-bit subexpression codes, and each code steers one 4:1 selector.

A small generator forms four multiples of the sample magnitude: zero, once, twice and three times. Only the three-times multiple costs an adder. The eight selected multiples are summed with their binary weights. The sign is applied once at the end: the sample sign and the coefficient sign are XOR-ed, and that result enables a two's complement of the summed magnitude.

A valid strobe travels with the data. The result appears on a registered 32-bit output with a fixed latency of two clock cycles. The datapath is sized for the worst-case coefficient, an all-ones magnitude. Because of this, any coefficient value may be loaded in any cycle without overflow.

Top module: `cse_const_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `out_valid` low and `product` equal to zero.
- R2: For a non-negative sample and a coefficient with sign bit 15 clear, `product` equals the sample times the coefficient magnitude (bits 14:0).
- R3: A coefficient with bit 15 set yields the negated product of the sample and the coefficient magnitude.
- R4: A negative two's-complement sample is handled through its magnitude. The result sign is the XOR of sample bit 15 and coefficient bit 15.
- R5: `out_valid` is high exactly two rising edges after a rising edge at which `in_valid` was high. The `product` shown with it belongs to the sample and coefficient presented at that earlier edge.
- R6: When `out_valid` is low, `product` keeps the value of the last valid result (zero after reset).
- R7: The all-ones magnitude 0x7FFF combined with the most negative sample -32768 gives the exact 32-bit product with no overflow: +1073709056 for a negative coefficient and -1073709056 for a positive one.
- R8: A coefficient magnitude of zero gives a product of zero for either coefficient sign, 0x0000 and 0x8000 alike.
- R9: The coefficient may change on every cycle while samples stream back to back. Each result uses the coefficient presented in the same cycle as its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample and coefficient are valid this cycle |
| sample | input | 16 | Signed two's-complement input sample |
| coef | input | 16 | Coefficient: bit 15 sign, bits 14:0 magnitude |
| out_valid | output | 1 | Product register holds a fresh result |
| product | output | 32 | Signed two's-complement product |

## Verification
Two things can happen in the same cycle. A new coefficient can be captured by the selector stage while the adder and complement stage is still finishing the previous sample, which was scaled by a different coefficient of possibly opposite sign. The bench provokes this by streaming valid samples on every cycle, with a fresh random coefficient and sign each time, so stage one and stage two always work on unrelated operands. A behavioural queue model predicts each product from the signed operands of its own cycle, and every clock is compared against that prediction. Any mixing of a coefficient or a sign across the pipeline boundary shows up as a wrong product or a wrong sign.

// File: rtl/cse_mul_pkg.sv
// Package: shared sizes for the two-bit subexpression multiplier.
// Assumes a sign-magnitude coefficient whose MSB is the sign, and a
// two's-complement sample. All derived widths are computed here.
package cse_mul_pkg;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned COEF_W   = 16;
    localparam int unsigned CODE_W   = 2;                          // bits per subexpression code
    localparam int unsigned NUM_MULT = 1 << CODE_W;                // multiples 0..3
    localparam int unsigned MAG_W    = COEF_W - 1;                 // coefficient magnitude bits
    localparam int unsigned NUM_CODE = (MAG_W + CODE_W - 1) / CODE_W;
    localparam int unsigned PAD_W    = NUM_CODE * CODE_W;          // padded magnitude width
    localparam int unsigned PP_W     = DATA_W + CODE_W;            // widest multiple (3x)
    localparam int unsigned PROD_W   = DATA_W + COEF_W;            // signed product width
endpackage

// File: rtl/cse_operand_prep.sv
// Module: cse_operand_prep
// Splits the signed sample into magnitude and sign, pads the coefficient
// magnitude to a whole number of codes, and forms the result sign.
// Assumes the most negative sample maps to the unsigned magnitude 2^(DW-1).
module cse_operand_prep #(
    parameter int unsigned DW  = 16,
    parameter int unsigned CW  = 16,
    parameter int unsigned PW  = 16
) (
    input  logic [DW-1:0] sample,
    input  logic [CW-1:0] coef,
    output logic [DW-1:0] x_mag,
    output logic [PW-1:0] c_mag,
    output logic          res_neg
);
    localparam int unsigned MW = CW - 1;

    // Absolute value of the sample; unsigned so -2^(DW-1) stays exact.
    always_comb begin
        if (sample[DW-1]) begin
            x_mag = (~sample) + DW'(1);
        end else begin
            x_mag = sample;
        end
    end

    // Zero-extend the coefficient magnitude to the padded code width.
    always_comb begin
        c_mag = PW'(coef[MW-1:0]);
    end

    // Result sign is the XOR of the two operand signs.
    always_comb begin
        res_neg = sample[DW-1] ^ coef[CW-1];
    end
endmodule

// File: rtl/cse_pp_gen.sv
// Module: cse_pp_gen
// Forms the four multiples of the sample magnitude needed by a 2-bit code:
// 0, X, 2X and 3X. Only 3X uses an adder (X + 2X); the rest are wiring.
// Assumes the code width is two bits, so exactly four multiples exist.
module cse_pp_gen #(
    parameter int unsigned DW = 16,
    parameter int unsigned PW = 18
) (
    input  logic [DW-1:0]         x_mag,
    output logic [3:0][PW-1:0]    pp
);
    logic [PW-1:0] x_ext;
    logic [PW-1:0] x_dbl;

    // Widen the magnitude and form the shifted copy.
    always_comb begin
        x_ext = PW'(x_mag);
        x_dbl = x_ext << 1;
    end

    // Assemble the multiple table; one adder for pattern 11.
    always_comb begin
        pp[0] = '0;
        pp[1] = x_ext;
        pp[2] = x_dbl;
        pp[3] = x_ext + x_dbl;
    end
endmodule

// File: rtl/cse_code_mux.sv
// Module: cse_code_mux
// One 4:1 selector: a 2-bit coefficient code picks one precomputed
// multiple of the sample magnitude. Assumes the codes map 00..11 to 0..3X.
module cse_code_mux #(
    parameter int unsigned PW = 18
) (
    input  logic [3:0][PW-1:0] pp,
    input  logic [1:0]         code,
    output logic [PW-1:0]      pick
);
    // Select the multiple named by the code.
    always_comb begin
        unique case (code)
            2'b00:   pick = pp[0];
            2'b01:   pick = pp[1];
            2'b10:   pick = pp[2];
            default: pick = pp[3];
        endcase
    end
endmodule

// File: rtl/cse_weight_sum.sv
// Module: cse_weight_sum
// Adds the selected multiples, each at its own weight (code k shifted left
// by 2k), in a chain whose adder widths grow only as far as each stage needs.
// Assumes the sum of all weighted multiples fits in SW bits.
module cse_weight_sum #(
    parameter int unsigned NC = 8,
    parameter int unsigned PW = 18,
    parameter int unsigned CB = 2,
    parameter int unsigned SW = 32
) (
    input  logic [NC-1:0][PW-1:0] picks,
    output logic [SW-1:0]         total
);
    logic [NC-1:0][SW-1:0] chain;

    for (genvar k = 0; k < NC; k++) begin : g_stage
        localparam int unsigned RAW = PW + CB * k + ((k > 0) ? 1 : 0);
        localparam int unsigned WID = (RAW > SW) ? SW : RAW;
        logic [WID-1:0] acc;
        if (k == 0) begin : g_first
            // First stage: the least-weight multiple passes straight through.
            always_comb acc = WID'(picks[k]);
        end else begin : g_add
            // Later stages: add this multiple at weight 2^(CB*k).
            always_comb acc = WID'(chain[k-1]) + (WID'(picks[k]) << (CB * k));
        end
        // Widen every stage result into the common chain array.
        always_comb chain[k] = SW'(acc);
    end

    // The last chain stage is the full magnitude.
    always_comb total = chain[NC-1];
endmodule

// File: rtl/cse_const_mul.sv
// Module: cse_const_mul (top)
// Signed sample times sign-magnitude coefficient via 2-bit subexpression
// shift-and-add. Stage 1 registers the eight selected multiples and the
// result sign. Stage 2 sums them, applies the sign and registers the result.
// Assumes a synchronous active-low reset; latency is two cycles.
module cse_const_mul
    import cse_mul_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DATA_W,
    parameter int unsigned COEFF_W  = COEF_W,
    parameter int unsigned RESULT_W = PROD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [COEFF_W-1:0]  coef,
    output logic                out_valid,
    output logic [RESULT_W-1:0] product
);
    localparam int unsigned M_W   = COEFF_W - 1;
    localparam int unsigned N_C   = (M_W + CODE_W - 1) / CODE_W;
    localparam int unsigned P_W   = N_C * CODE_W;
    localparam int unsigned MUL_W = SAMPLE_W + CODE_W;

    logic [SAMPLE_W-1:0]        x_mag;
    logic [P_W-1:0]             c_mag;
    logic                       res_neg;
    logic [3:0][MUL_W-1:0]      pp;
    logic [N_C-1:0][MUL_W-1:0]  picks;
    logic [N_C-1:0][MUL_W-1:0]  picks_q;
    logic                       neg_q;
    logic                       vld_q;
    logic [RESULT_W-1:0]        mag_sum;
    logic [RESULT_W-1:0]        signed_res;
    logic [RESULT_W-1:0]        product_q;
    logic                       out_valid_q;

    cse_operand_prep #(.DW(SAMPLE_W), .CW(COEFF_W), .PW(P_W)) u_prep (
        .sample  (sample),
        .coef    (coef),
        .x_mag   (x_mag),
        .c_mag   (c_mag),
        .res_neg (res_neg)
    );

    cse_pp_gen #(.DW(SAMPLE_W), .PW(MUL_W)) u_ppg (
        .x_mag (x_mag),
        .pp    (pp)
    );

    for (genvar k = 0; k < N_C; k++) begin : g_mux
        cse_code_mux #(.PW(MUL_W)) u_mux (
            .pp   (pp),
            .code (c_mag[CODE_W*k +: CODE_W]),
            .pick (picks[k])
        );
    end

    // Stage 1: capture the selected multiples and sign with each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            picks_q <= '0;
            neg_q   <= 1'b0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                picks_q <= picks;
                neg_q   <= res_neg;
            end
        end
    end

    cse_weight_sum #(.NC(N_C), .PW(MUL_W), .CB(CODE_W), .SW(RESULT_W)) u_sum (
        .picks (picks_q),
        .total (mag_sum)
    );

    // Two's complementer enabled by the combined sign.
    always_comb begin
        if (neg_q) begin
            signed_res = (~mag_sum) + RESULT_W'(1);
        end else begin
            signed_res = mag_sum;
        end
    end

    // Stage 2: register the signed result; hold it across idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product_q   <= '0;
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= vld_q;
            if (vld_q) begin
                product_q <= signed_res;
            end
        end
    end

    assign product   = product_q;
    assign out_valid = out_valid_q;
endmodule

// File: rtl/cse_const_mul_chk.sv
// Module: cse_const_mul_chk
// Port-level properties of the multiplier, attached to the top by bind.
// Assumes the two-cycle latency; a small counter gates history look-backs.
module cse_const_mul_chk #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned COEFF_W  = 16,
    parameter int unsigned RESULT_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] sample,
    input logic [COEFF_W-1:0]  coef,
    input logic                out_valid,
    input logic [RESULT_W-1:0] product
);
    logic [1:0] run_cnt;
    logic       seen_edge = 1'b0;
    logic       was_reset = 1'b0;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        was_reset <= !rst_n;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        (seen_edge && was_reset) |-> (!out_valid && product == '0));

    // R5
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd1 && !out_valid) |-> $stable(product));

    // R8
    zero_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2 && out_valid && $past(coef[COEFF_W-2:0] == '0, 2))
        |-> (product == '0));

    // R3 R4
    result_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2 && out_valid && product != '0)
        |-> (product[RESULT_W-1] == ($past(sample[SAMPLE_W-1], 2) ^ $past(coef[COEFF_W-1], 2))));
endmodule

bind cse_const_mul cse_const_mul_chk #(
    .SAMPLE_W (SAMPLE_W),
    .COEFF_W  (COEFF_W),
    .RESULT_W (RESULT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sample    (sample),
    .coef      (coef),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/tb_cse_const_mul.sv
// Bench: behavioural queue model of the two-cycle multiplier, compared at
// every falling edge. Inputs change at falling edges only.
module tb_cse_const_mul;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] sample = '0;
    logic [15:0] coef = '0;
    logic        out_valid;
    logic [31:0] product;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    typedef struct {
        bit    v;
        int    p;
        string tag;
    } exp_t;

    exp_t q[$];
    int   hold_val = 0;

    cse_const_mul dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sample    (sample),
        .coef      (coef),
        .out_valid (out_valid),
        .product   (product)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int ref_prod(logic [15:0] s, logic [15:0] c);
        longint a = longint'($signed(s));
        longint m = longint'({1'b0, c[14:0]});
        if (c[15]) m = -m;
        return int'(a * m);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare outputs against the model entry from two edges back.
    task automatic compare();
        exp_t e;
        if (q.size() >= 2) begin
            e = q.pop_front();
            if (e.v) hold_val = e.p;
            check(out_valid === e.v, "R5", "out_valid", longint'(out_valid), longint'(e.v));
            check(product === hold_val, e.v ? e.tag : "R6", "product",
                  longint'($signed(product)), longint'(hold_val));
        end
    endtask

    task automatic cycle(bit v, logic [15:0] s, logic [15:0] c, string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        sample   = s;
        coef     = c;
        @(posedge clk);
        #1;
        q.push_back('{v, ref_prod(s, c), tag});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1", "out_valid", longint'(out_valid), 0);
        check(product === 32'd0, "R1", "product", longint'(product), 0);
        rst_n = 1'b1;

        cycle(1, 16'd100, 16'h0005, "R2");
        cycle(1, 16'd32767, 16'h1234, "R2");
        cycle(1, 16'd100, 16'h8005, "R3");
        cycle(1, 16'd32767, 16'hFFFF, "R3");
        cycle(1, 16'hFF9C, 16'h0005, "R4");
        cycle(1, 16'hFF9C, 16'h8005, "R4");
        cycle(1, 16'h8000, 16'hFFFF, "R7");
        cycle(1, 16'h8000, 16'h7FFF, "R7");
        cycle(1, 16'h7FFF, 16'h7FFF, "R7");
        cycle(1, 16'd1234, 16'h0000, "R8");
        cycle(1, 16'hFB2E, 16'h8000, "R8");
        // R6: idle cycles with changing operands must not disturb the result
        for (int i = 0; i < 6; i++) cycle(0, 16'($urandom), 16'($urandom), "R6");
        // R9: back-to-back samples, fresh coefficient every cycle
        for (int i = 0; i < 400; i++) cycle(1, 16'($urandom), 16'($urandom), "R9");
        // R2: sparse mixed traffic
        for (int i = 0; i < 300; i++)
            cycle(($urandom % 3) != 0, 16'($urandom), 16'($urandom), "R2");
        for (int i = 0; i < 4; i++) cycle(0, 16'h0, 16'h0, "R6");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule